// File: doc/BRIEF.md
# Power Rail Sequencer and Mode Controller

This block decides when each of the eight supply rails of a power-management unit is switched on or off, and when the host processor comes out of reset. A power-up can be started by a power key or by an external wake input. Each of these inputs must stay at its new level for a set number of timebase ticks before it is accepted. The rails then come up one at a time in a fixed order, with programmable tick delays between them. After a final delay, reset is released. From then on the host keeps power on by holding a latch input high.

Once running, the unit can be in one of two modes. In normal mode all rails are on. In sleep mode, which a low run-enable input selects, the rails gated by run-enable are off. The host can also request deep sleep. In deep sleep only the retention rails stay on, and only a new key press or external wake brings the unit back, through the full power-up sequence. All asynchronous inputs pass through two-flop synchronizers. Every delay is a parameter counted in ticks of an external timebase.

Rail bit positions in `rail_en_o`:

| Bit | Rail |
| --- | --- |
| 0 | always-on clock rail |
| 1 | pre-core |
| 2 | core buck |
| 3 | I/O |
| 4 | memory buck |
| 5 | PLL |
| 6 | converter/PHY |
| 7 | audio |

Two groups of rails matter below:
- The gated set is bits 2, 5, 6 and 7.
- The retention set is bits 0, 1, 3 and 4.

Top module: `pwrseq_top`

## Requirements
- R1: The values held during and right after reset are:
  - `rail_en_o` is 0.
  - `rst_n_o` is 0.
  - `run_mask_o` is 0.
  - `key_stat_n_o` is 1.
- R2: A key or external-wake level is accepted only after it has stayed at its new value, after synchronization, for `DEB_TICKS` ticks. A shorter pulse starts nothing.
- R3: A wake from off or from deep sleep is refused while the synchronized low-battery input is 1.
- R4: A power-up turns rails on in bit order 0 through 7, one bit per step. The wait after bit 1 is `GAP_TICKS`. Every other step waits `STEP_TICKS`. Rails that are already on stay on.
- R5: Reset is released `RST_TICKS` ticks after bit 7 turns on. `run_mask_o` is 1 only while reset is released and the unit is in normal or sleep mode.
- R6: In normal or sleep mode, the gated set follows the synchronized run-enable: all eight rails (0xFF) when it is 1, the retention set (0x1B) when it is 0.
- R7: In normal, sleep or deep sleep, hold low with the debounced key released powers down. Only bit 0 stays on, `rst_n_o` goes to 0 and `run_mask_o` goes to 0. Hold high keeps power on after the key is released.
- R8: An accepted rising level on the external-wake input starts the power-up sequence from off.
- R9: Deep sleep is entered only when the deep-sleep request rises while the ready input is already 1. In deep sleep:
  - `rail_en_o` is 0x1B.
  - `rst_n_o` is 1.
  - `run_mask_o` is 0.
  - run-enable has no effect.
- R10: An accepted key press in deep sleep reruns the full power-up sequence. Reset is asserted again and then released, and the unit ends in normal mode.
- R11: The low-battery input has no effect in normal or sleep mode.
- R12: `key_stat_n_o` is the inverse of the debounced key level, one cycle later.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| tick_i | input | 1 | one-cycle timebase pulse |
| key_i | input | 1 | power key, asynchronous, high when pressed |
| ext_on_i | input | 1 | external wake level, asynchronous |
| hold_i | input | 1 | host power latch, asynchronous |
| run_en_i | input | 1 | host run-enable, asynchronous |
| ds_ready_i | input | 1 | host deep-sleep ready, asynchronous |
| ds_req_i | input | 1 | host deep-sleep request, asynchronous |
| low_bat_i | input | 1 | low-battery flag, asynchronous |
| rail_en_o | output | 8 | per-rail enables, bit map above |
| key_stat_n_o | output | 1 | key status to host, active low |
| rst_n_o | output | 1 | host reset, active low |
| run_mask_o | output | 1 | 1 when run-enable is allowed to gate the core buck |

## Verification
The bench builds the block with the following scaled-down values, which make a complete power-up take under a hundred cycles:

| Parameter | Value |
| --- | --- |
| `DEB_TICKS` | 4 |
| `STEP_TICKS` | 2 |
| `GAP_TICKS` | 5 |
| `RST_TICKS` | 6 |
| tick period | one tick every three clocks |

At these values a single run can cover the whole life cycle: the key glitch, wakes refused for low battery, sleep, deep sleep, deep-sleep exit, shutdown and external wake. The longer pre-core-to-core gap is still clearly different from the ordinary step, so the bench can check the spacing as well as the order.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int NUM_RAILS = 8;
  localparam int STEP_W    = $clog2(NUM_RAILS);
  localparam int LAST_STEP = NUM_RAILS - 1;

  // rail groups by bit position
  localparam logic [NUM_RAILS-1:0] RTC_SET    = 8'h01;
  localparam logic [NUM_RAILS-1:0] RETAIN_SET = 8'h1B;
  localparam logic [NUM_RAILS-1:0] ALL_SET    = 8'hFF;

  // synchronized input bit positions
  localparam int SI_KEY   = 0;
  localparam int SI_EXT   = 1;
  localparam int SI_HOLD  = 2;
  localparam int SI_RUN   = 3;
  localparam int SI_READY = 4;
  localparam int SI_DSREQ = 5;
  localparam int SI_LOWB  = 6;
  localparam int SI_W     = 7;
  localparam int NUM_DEB  = 2;

  typedef enum logic [2:0] {
    PS_OFF, PS_SEQ, PS_RUN, PS_SLEEP, PS_DEEP
  } pstate_t;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pwrseq_debounce.sv
module pwrseq_debounce #(
  parameter int DEB_TICKS = 3200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic level,
  output logic rise
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      cnt   <= '0;
      rise  <= 1'b0;
    end else begin
      rise <= 1'b0;
      if (din == level) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) begin
          level <= din;
          cnt   <= '0;
          rise  <= din;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int STEP_TICKS = 1,
  parameter int GAP_TICKS  = 7,
  parameter int RST_TICKS  = 2000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 key_lvl,
  input  logic                 key_rise,
  input  logic                 ext_rise,
  input  logic                 hold,
  input  logic                 run_en,
  input  logic                 ds_ready,
  input  logic                 ds_req,
  input  logic                 low_bat,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 rst_n,
  output logic                 run_mask,
  output logic                 key_stat_n
);
  localparam int MAXT = (STEP_TICKS > GAP_TICKS) ?
                        ((STEP_TICKS > RST_TICKS) ? STEP_TICKS : RST_TICKS) :
                        ((GAP_TICKS > RST_TICKS) ? GAP_TICKS : RST_TICKS);
  localparam int CW = $clog2(MAXT + 1);
  localparam int PW = NUM_RAILS + 1;

  pstate_t           state, state_d;
  logic [STEP_W-1:0] step, step_d;
  logic [CW-1:0]     tcnt, tcnt_d;
  logic              ds_prev;
  logic              wake, drop, ds_enter;
  logic [CW-1:0]     limit;
  logic [PW-1:0]     prefix;
  logic [NUM_RAILS-1:0] rail_d;

  assign wake     = (key_rise | ext_rise) & ~low_bat;
  assign drop     = ~hold & ~key_lvl;
  assign ds_enter = ds_req & ~ds_prev & ds_ready;

  always_comb begin
    if (step == STEP_W'(1))              limit = CW'(GAP_TICKS - 1);
    else if (step == STEP_W'(LAST_STEP)) limit = CW'(RST_TICKS - 1);
    else                                 limit = CW'(STEP_TICKS - 1);
  end

  always_comb begin
    state_d = state;
    step_d  = step;
    tcnt_d  = tcnt;
    case (state)
      PS_OFF: if (wake) begin
        state_d = PS_SEQ; step_d = '0; tcnt_d = '0;
      end
      PS_SEQ: if (tick) begin
        if (tcnt == limit) begin
          tcnt_d = '0;
          if (step == STEP_W'(LAST_STEP)) begin
            state_d = run_en ? PS_RUN : PS_SLEEP;
            step_d  = '0;
          end else begin
            step_d = step + 1'b1;
          end
        end else begin
          tcnt_d = tcnt + 1'b1;
        end
      end
      PS_RUN, PS_SLEEP: begin
        if (drop)          state_d = PS_OFF;
        else if (ds_enter) state_d = PS_DEEP;
        else               state_d = run_en ? PS_RUN : PS_SLEEP;
      end
      PS_DEEP: begin
        if (wake) begin
          state_d = PS_SEQ; step_d = '0; tcnt_d = '0;
        end else if (drop) begin
          state_d = PS_OFF;
        end
      end
      default: state_d = PS_OFF;
    endcase
  end

  always_comb begin
    prefix = (PW'(2) << step_d) - PW'(1);
    case (state_d)
      PS_OFF:   rail_d = rail_en & RTC_SET;
      PS_SEQ:   rail_d = rail_en | prefix[NUM_RAILS-1:0];
      PS_RUN:   rail_d = ALL_SET;
      default:  rail_d = RETAIN_SET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PS_OFF;
      step       <= '0;
      tcnt       <= '0;
      ds_prev    <= 1'b0;
      rail_en    <= '0;
      rst_n      <= 1'b0;
      run_mask   <= 1'b0;
      key_stat_n <= 1'b1;
    end else begin
      state      <= state_d;
      step       <= step_d;
      tcnt       <= tcnt_d;
      ds_prev    <= ds_req;
      rail_en    <= rail_d;
      rst_n      <= (state_d == PS_RUN) || (state_d == PS_SLEEP) || (state_d == PS_DEEP);
      run_mask   <= (state_d == PS_RUN) || (state_d == PS_SLEEP);
      key_stat_n <= ~key_lvl;
    end
  end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int DEB_TICKS  = 3200,
  parameter int STEP_TICKS = 1,
  parameter int GAP_TICKS  = 7,
  parameter int RST_TICKS  = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       key_i,
  input  logic       ext_on_i,
  input  logic       hold_i,
  input  logic       run_en_i,
  input  logic       ds_ready_i,
  input  logic       ds_req_i,
  input  logic       low_bat_i,
  output logic [7:0] rail_en_o,
  output logic       key_stat_n_o,
  output logic       rst_n_o,
  output logic       run_mask_o
);
  logic [SI_W-1:0]    raw, syn;
  logic [NUM_DEB-1:0] db_lvl, db_rise;

  assign raw = {low_bat_i, ds_req_i, ds_ready_i, run_en_i, hold_i, ext_on_i, key_i};

  pwrseq_sync #(.W(SI_W)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  for (genvar g = 0; g < NUM_DEB; g++) begin : g_deb
    pwrseq_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
      .clk(clk), .rst(rst), .tick(tick_i), .din(syn[g]),
      .level(db_lvl[g]), .rise(db_rise[g])
    );
  end

  pwrseq_fsm #(
    .STEP_TICKS(STEP_TICKS), .GAP_TICKS(GAP_TICKS), .RST_TICKS(RST_TICKS)
  ) u_fsm (
    .clk(clk), .rst(rst), .tick(tick_i),
    .key_lvl(db_lvl[SI_KEY]), .key_rise(db_rise[SI_KEY]), .ext_rise(db_rise[SI_EXT]),
    .hold(syn[SI_HOLD]), .run_en(syn[SI_RUN]), .ds_ready(syn[SI_READY]),
    .ds_req(syn[SI_DSREQ]), .low_bat(syn[SI_LOWB]),
    .rail_en(rail_en_o), .rst_n(rst_n_o), .run_mask(run_mask_o),
    .key_stat_n(key_stat_n_o)
  );
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] rail_en_o,
  input logic       rst_n_o,
  input logic       run_mask_o
);
  // R5
  mask_needs_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_n_o |-> !run_mask_o);
  // R7
  rtc_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (|rail_en_o[7:1]) |-> (rail_en_o[1] && rail_en_o[0]));
  // R6
  retain_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    run_mask_o |-> ((rail_en_o & 8'h1B) == 8'h1B));
  // R5
  release_after_rails_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> ((rail_en_o & 8'h1B) == 8'h1B));
  // R4
  last_rail_order_chk: assert property (@(posedge clk) disable iff (rst)
    rail_en_o[7] |-> (&rail_en_o[6:0]));
endmodule

bind pwrseq_top pwrseq_chk u_chk (
  .clk(clk), .rst(rst), .rail_en_o(rail_en_o), .rst_n_o(rst_n_o), .run_mask_o(run_mask_o)
);

// File: tb/sim_pwrseq_top.sv
module sim_pwrseq_top;
  localparam int PERIOD = 10;
  localparam int DEB = 4, STEPT = 2, GAPT = 5, RSTT = 6, TDIV = 3;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic key = 0, ext = 0, hold = 0, run = 1, ready = 0, dsreq = 0, lowb = 0;
  logic [7:0] rail;
  logic keyn, rstn, mask;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pwrseq_top #(.DEB_TICKS(DEB), .STEP_TICKS(STEPT), .GAP_TICKS(GAPT), .RST_TICKS(RSTT)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .key_i(key), .ext_on_i(ext), .hold_i(hold),
    .run_en_i(run), .ds_ready_i(ready), .ds_req_i(dsreq), .low_bat_i(lowb),
    .rail_en_o(rail), .key_stat_n_o(keyn), .rst_n_o(rstn), .run_mask_o(mask)
  );

  // ---------------- reference model ----------------
  int m_mode = 0, m_step = 0, m_tcnt = 0;   // 0 off,1 seq,2 run,3 sleep,4 deep
  bit [7:0] m_rail = 0;
  bit m_rstn = 0, m_mask = 0, m_keyn = 1, m_dsp = 0;
  bit [6:0] m_s1 = 0, m_s2 = 0;
  bit m_dbo[2], m_dbr[2];
  int m_dbc[2];

  function automatic int wait_of(int s);
    if (s == 1) return GAPT;
    if (s == 7) return RSTT;
    return STEPT;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_step = 0; m_tcnt = 0; m_rail = 0; m_rstn = 0; m_mask = 0;
      m_keyn = 1; m_dsp = 0; m_s1 = 0; m_s2 = 0;
      for (int k = 0; k < 2; k++) begin m_dbo[k] = 0; m_dbr[k] = 0; m_dbc[k] = 0; end
    end else begin
      bit [6:0] sv;
      int nm, ns;
      bit wake, drop, dse;
      sv = m_s2; nm = m_mode; ns = m_step;
      wake = (m_dbr[0] || m_dbr[1]) && !sv[6];
      drop = !sv[2] && !m_dbo[0];
      dse  = sv[5] && !m_dsp && sv[4];
      case (m_mode)
        0: if (wake) begin nm = 1; ns = 0; m_tcnt = 0; end
        1: if (tick) begin
             if (m_tcnt == wait_of(m_step) - 1) begin
               m_tcnt = 0;
               if (m_step == 7) begin nm = sv[3] ? 2 : 3; ns = 0; end
               else ns = m_step + 1;
             end else m_tcnt++;
           end
        2, 3: if (drop) nm = 0; else if (dse) nm = 4; else nm = sv[3] ? 2 : 3;
        default: if (wake) begin nm = 1; ns = 0; m_tcnt = 0; end else if (drop) nm = 0;
      endcase
      m_mode = nm; m_step = ns;
      case (nm)
        0: m_rail = m_rail & 8'h01;
        1: m_rail = m_rail | 8'((1 << (ns + 1)) - 1);
        2: m_rail = 8'hFF;
        default: m_rail = 8'h1B;
      endcase
      m_rstn = (nm >= 2);
      m_mask = (nm == 2) || (nm == 3);
      m_keyn = !m_dbo[0];
      m_dsp  = sv[5];
      for (int k = 0; k < 2; k++) begin
        m_dbr[k] = 0;
        if (sv[k] == m_dbo[k]) m_dbc[k] = 0;
        else if (tick) begin
          if (m_dbc[k] == DEB - 1) begin m_dbo[k] = sv[k]; m_dbc[k] = 0; m_dbr[k] = sv[k]; end
          else m_dbc[k]++;
        end
      end
      m_s2 = m_s1;
      m_s1 = {lowb, dsreq, ready, run, hold, ext, key};
    end
  end

  // ---------------- checking ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  int rise_t[8];
  logic [7:0] prev_rail = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(rail == m_rail, "R4 rails vs model", rail, m_rail);
      chk(rstn == m_rstn, "R5 reset vs model", rstn, m_rstn);
      chk(mask == m_mask, "R6 mask vs model", mask, m_mask);
      chk(keyn == m_keyn, "R12 key status vs model", keyn, m_keyn);
      for (int i = 0; i < 8; i++)
        if (rail[i] && !prev_rail[i] && rise_t[i] == 0) rise_t[i] = cyc;
      prev_rail = rail;
    end
  end

  // timebase
  initial begin
    forever begin
      repeat (TDIV - 1) @(posedge clk);
      #2 tick = 1;
      @(posedge clk);
      #2 tick = 0;
    end
  end

  task automatic cyc_wait(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_seq();
    int n = 0;
    while (rstn !== 1'b0 && n < 500) begin @(negedge clk); n++; end
    while (rstn !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) rise_t[i] = 0;
    cyc_wait(3);
    rst = 0;
    cyc_wait(1);
    chk(rail == 8'h00 && rstn == 0 && mask == 0 && keyn == 1, "R1 reset state",
        {rail, rstn, mask, keyn}, 8'h00 << 3 | 3'b001);

    // R2: glitch shorter than the debounce window
    key = 1; cyc_wait(6); key = 0; cyc_wait(30);
    chk(rail == 8'h00, "R2 short key pulse ignored", rail, 0);

    // R3: low battery blocks power-up; R12 key status follows debounced key
    lowb = 1; cyc_wait(5);
    key = 1; cyc_wait(40);
    chk(rail == 8'h00, "R3 low battery blocks wake", rail, 0);
    chk(keyn == 0, "R12 key status low while pressed", keyn, 0);
    key = 0; cyc_wait(30); lowb = 0; cyc_wait(5);

    // R4/R5: full sequence from key
    key = 1; wait_seq();
    chk(rail == 8'hFF && mask == 1, "R5 normal after reset release", {rail, mask}, 9'h1FF);
    begin
      bit ord = 1;
      for (int i = 1; i < 8; i++) if (rise_t[i] <= rise_t[i-1]) ord = 0;
      chk(ord, "R4 rail order", ord, 1);
      chk((rise_t[2] - rise_t[1]) > (rise_t[3] - rise_t[2]), "R4 longer gap before core",
          rise_t[2] - rise_t[1], rise_t[3] - rise_t[2]);
    end
    hold = 1; cyc_wait(3); key = 0; cyc_wait(30);
    chk(rail == 8'hFF && rstn == 1, "R7 hold keeps power", rail, 8'hFF);

    // R11
    lowb = 1; cyc_wait(20);
    chk(rail == 8'hFF && mask == 1, "R11 low battery ignored in normal", rail, 8'hFF);
    run = 0; cyc_wait(10);
    chk(rail == 8'h1B && mask == 1, "R11 low battery ignored in sleep", rail, 8'h1B);
    run = 1; lowb = 0; cyc_wait(10);

    // R6
    run = 0; cyc_wait(10);
    chk(rail == 8'h1B && mask == 1, "R6 sleep rails", rail, 8'h1B);
    run = 1; cyc_wait(10);
    chk(rail == 8'hFF, "R6 back to normal", rail, 8'hFF);

    // R9: request without ready ignored, then with ready
    dsreq = 1; cyc_wait(10);
    chk(rail == 8'hFF && mask == 1, "R9 request without ready ignored", rail, 8'hFF);
    dsreq = 0; cyc_wait(5); ready = 1; cyc_wait(5); dsreq = 1; cyc_wait(10);
    chk(rail == 8'h1B && mask == 0 && rstn == 1, "R9 deep sleep entered", {rail, mask}, 9'h036);
    run = 0; cyc_wait(10);
    chk(rail == 8'h1B, "R9 run-enable ignored in deep", rail, 8'h1B);
    run = 1; cyc_wait(10);
    chk(rail == 8'h1B && mask == 0, "R9 run-enable high ignored in deep", rail, 8'h1B);

    // R10 with R3 from deep
    lowb = 1; cyc_wait(5); key = 1; cyc_wait(40);
    chk(rail == 8'h1B && rstn == 1, "R3 low battery blocks deep exit", rail, 8'h1B);
    key = 0; cyc_wait(30); lowb = 0; cyc_wait(5);
    key = 1; wait_seq();
    chk(rail == 8'hFF && mask == 1, "R10 deep exit via sequence", rail, 8'hFF);
    key = 0; dsreq = 0; ready = 0; cyc_wait(30);

    // R7 power down
    hold = 0; cyc_wait(10);
    chk(rail == 8'h01 && rstn == 0 && mask == 0, "R7 power down keeps clock rail", rail, 8'h01);

    // R8 external wake
    hold = 1; ext = 1; wait_seq();
    chk(rail == 8'hFF && mask == 1, "R8 external wake", rail, 8'hFF);
    ext = 0; cyc_wait(20);
    chk(rail == 8'hFF, "R8 stays on after wake released", rail, 8'hFF);

    cyc_wait(5);
    finish_run();
  end
endmodule